// File: doc/BRIEF.md
# I2S to Parallel-Latch Ladder DAC Formatter

This block accepts a stereo I2S stream and turns every complete left/right sample pair into the burst that resistor-ladder DACs expect when no oversampling filter sits in front of them. The output has one shared bit clock, a data line for each channel, and a latch strobe. Both channels shift out MSB first on the same bit clock edges. A single falling latch edge then converts both channels together, so the two channels never drift apart in phase.

Everything runs from one master clock. The I2S pins are brought into that domain through synchronizers, and a pair is only released once it has been fully received. The output bit clock runs at the master clock divided by a programmable ratio. Configuration pins choose the word width, a burst-only or free-running bit clock, an optional priming pulse before the data, optional trailing pulses after the latch, and a second latch pin for a pair of mono DACs.

When the output is burst-only, every output sits low between bursts. This keeps digital activity away from the converters while they settle.

Top module: `dac_frame_formatter`

## Requirements
- R1: `cfg_width` selects the bits per channel: 0 gives 16, 1 gives 18, 2 gives 20 and 3 gives 24. Each burst carries exactly that many data bits per channel, MSB first, and the last data bit sits on the final bit clock rise before the latch rises.
- R2: When the received I2S word is longer than 24 bits, only its 24 most significant bits are kept. The burst carries the top `cfg_width` bits of those 24.
- R3: When the received I2S word is shorter than 24 bits, it is left-aligned and its missing low bits are zero, so a 16-bit word shown at 24 bits ends in eight zeros.
- R4: `dac_dl` carries the left word and `dac_dr` carries the right word, both on the same bit clock. Data changes only while `dac_bck` falls or is low, and it is stable across every rising edge of `dac_bck`.
- R5: With `cfg_cont` low, `dac_bck` pulses exactly (lead + width) times after the previous burst's trailing pulses, and it stays low while `dac_le` is high.
- R6: After the last data bit, `dac_le` is high for one bit clock period with both data lines low, then falls. With `cfg_cont` low, all outputs then stay low until the next burst starts.
- R7: With `cfg_cont` high, `dac_bck` toggles without pause, including during the latch period (one rise while `dac_le` is high) and between bursts, while data and latch still follow R4 and R6.
- R8: With `cfg_tail` high, exactly 2 bit clock pulses with both data lines low follow the falling edge of `dac_le`.
- R9: With `cfg_lead` high, one extra bit clock pulse with both data lines low comes before the first data bit.
- R10: `dac_le_aux` follows `dac_le` when `cfg_mono` is high and stays low when it is low.
- R11: After reset, all outputs are low. No burst is issued until a full left word followed by a full right word has been received after the first word-select change. Exactly one burst is issued per received pair.
- R12: The period of `dac_bck` is 2 × `cfg_div` master clock cycles, for `cfg_div` of 1 or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i2s_bck | input | 1 | I2S bit clock (asynchronous) |
| i2s_ws | input | 1 | I2S word select, 0 = left |
| i2s_sd | input | 1 | I2S serial data |
| cfg_width | input | 2 | Output width code (R1) |
| cfg_div | input | 8 | Master clocks per half bit-clock period |
| cfg_lead | input | 1 | Enable priming pulse |
| cfg_tail | input | 1 | Enable trailing pulses |
| cfg_cont | input | 1 | Free-running bit clock |
| cfg_mono | input | 1 | Drive second latch pin for dual mono |
| dac_bck | output | 1 | DAC bit clock |
| dac_dl | output | 1 | Left data |
| dac_dr | output | 1 | Right data |
| dac_le | output | 1 | Latch strobe, converts on falling edge |
| dac_le_aux | output | 1 | Copy of latch for the second mono DAC |

## Verification
A faulty capture bit counter or a misaligned word-select tracker shows up at the ports as shifted or wrong data words in the very next burst. A stuck pending flag shows up as a missing or repeated burst within one frame. A sequencer slot counter that is off by one changes the number of bit clock rises before the latch, or leaves clock pulses running while the latch is high. The bench catches this at that burst's latch edge. Phase or divider faults change the rise-to-rise spacing measured on the last data bit.

// File: rtl/dacfmt_pkg.sv
package dacfmt_pkg;
  localparam int unsigned WORD_W = 24;

  typedef enum logic [2:0] {SQ_IDLE, SQ_LEAD, SQ_SHIFT, SQ_LATCH, SQ_TAIL} seq_e;

  // bits per channel for a width code
  function automatic logic [4:0] width_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd16;
      2'd1:    return 5'd18;
      2'd2:    return 5'd20;
      default: return 5'd24;
    endcase
  endfunction

  // keep the n most significant bits, clear the rest
  function automatic logic [WORD_W-1:0] keep_top(input logic [WORD_W-1:0] w, input logic [4:0] n);
    return w & ~({WORD_W{1'b1}} >> n);
  endfunction

  // drop bit b into a left-aligned accumulator at position idx (0 = MSB)
  function automatic logic [WORD_W-1:0] place_bit(input logic [WORD_W-1:0] acc,
                                                  input logic [5:0] idx, input logic b);
    logic [WORD_W-1:0] r;
    r = acc;
    if (idx < 6'(WORD_W)) r = acc | (WORD_W'(b) << (6'(WORD_W - 1) - idx));
    return r;
  endfunction
endpackage

// File: rtl/i2s_pair_capture.sv
module i2s_pair_capture
  import dacfmt_pkg::*;
#(
  parameter int unsigned CNT_W = $clog2(WORD_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bck,
  input  logic              ws,
  input  logic              sd,
  output logic              pair_stb,
  output logic [WORD_W-1:0] word_l,
  output logic [WORD_W-1:0] word_r
);
  logic [2:0]        bck_sr;
  logic [1:0]        ws_sr, sd_sr;
  logic              ws_last, locked, have_left;
  logic [WORD_W-1:0] acc, done_word;
  logic [CNT_W-1:0]  nbit;
  logic              bck_rise;

  assign bck_rise  = bck_sr[1] & ~bck_sr[2];
  assign done_word = place_bit(acc, 6'(nbit), sd_sr[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bck_sr <= '0; ws_sr <= '0; sd_sr <= '0;
      ws_last <= 1'b0; locked <= 1'b0; have_left <= 1'b0;
      acc <= '0; nbit <= '0; pair_stb <= 1'b0;
      word_l <= '0; word_r <= '0;
    end else begin
      bck_sr   <= {bck_sr[1:0], bck};
      ws_sr    <= {ws_sr[0], ws};
      sd_sr    <= {sd_sr[0], sd};
      pair_stb <= 1'b0;
      if (bck_rise) begin
        if (ws_sr[1] != ws_last) begin
          // this bit is the LSB slot of the word that just ended
          ws_last <= ws_sr[1];
          locked  <= 1'b1;
          acc     <= '0;
          nbit    <= '0;
          if (locked) begin
            if (!ws_last) begin
              word_l    <= done_word;
              have_left <= 1'b1;
            end else if (have_left) begin
              word_r    <= done_word;
              pair_stb  <= 1'b1;
              have_left <= 1'b0;
            end
          end
        end else begin
          acc <= done_word;
          if (nbit != '1) nbit <= nbit + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/half_tick_div.sv
module half_tick_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt, lim;

  assign lim  = (div == '0) ? '0 : div - 1'b1;
  assign tick = (cnt >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/slot_sequencer.sv
module slot_sequencer
  import dacfmt_pkg::*;
#(
  parameter int unsigned TAIL_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              pair_stb,
  input  logic [WORD_W-1:0] word_l,
  input  logic [WORD_W-1:0] word_r,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_lead,
  input  logic              cfg_tail,
  output logic              ph,
  output logic              slot_clk,
  output logic              dl,
  output logic              dr,
  output logic              le,
  output logic              slot_start,
  output seq_e              state
);
  localparam int unsigned CW = $clog2(WORD_W + TAIL_CLKS + 1);

  logic              pend;
  logic [WORD_W-1:0] buf_l, buf_r, sh_l, sh_r;
  logic [CW-1:0]     cnt;
  logic [4:0]        nb;

  assign nb         = width_bits(cfg_width);
  assign slot_start = tick & ph;   // bit clock falls here: new slot

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= 1'b0; slot_clk <= 1'b0; dl <= 1'b0; dr <= 1'b0; le <= 1'b0;
      pend <= 1'b0; buf_l <= '0; buf_r <= '0; sh_l <= '0; sh_r <= '0;
      cnt <= '0; state <= SQ_IDLE;
    end else begin
      if (tick) ph <= ~ph;
      if (pair_stb) begin
        buf_l <= word_l;
        buf_r <= word_r;
        pend  <= 1'b1;
      end
      if (slot_start) begin
        case (state)
          SQ_IDLE: begin
            slot_clk <= 1'b0;
            if (pend) begin
              pend     <= pair_stb;
              slot_clk <= 1'b1;
              if (cfg_lead) begin
                state <= SQ_LEAD;
                sh_l  <= keep_top(buf_l, nb);
                sh_r  <= keep_top(buf_r, nb);
              end else begin
                state <= SQ_SHIFT;
                dl    <= buf_l[WORD_W-1];
                dr    <= buf_r[WORD_W-1];
                sh_l  <= keep_top(buf_l, nb) << 1;
                sh_r  <= keep_top(buf_r, nb) << 1;
                cnt   <= CW'(nb - 5'd1);
              end
            end
          end
          SQ_LEAD: begin
            state <= SQ_SHIFT;
            dl    <= sh_l[WORD_W-1];
            dr    <= sh_r[WORD_W-1];
            sh_l  <= sh_l << 1;
            sh_r  <= sh_r << 1;
            cnt   <= CW'(nb - 5'd1);
          end
          SQ_SHIFT: begin
            if (cnt != '0) begin
              dl   <= sh_l[WORD_W-1];
              dr   <= sh_r[WORD_W-1];
              sh_l <= sh_l << 1;
              sh_r <= sh_r << 1;
              cnt  <= cnt - 1'b1;
            end else begin
              state    <= SQ_LATCH;
              slot_clk <= 1'b0;
              dl       <= 1'b0;
              dr       <= 1'b0;
              le       <= 1'b1;
            end
          end
          SQ_LATCH: begin
            le <= 1'b0;
            if (cfg_tail) begin
              state    <= SQ_TAIL;
              slot_clk <= 1'b1;
              cnt      <= CW'(TAIL_CLKS - 1);
            end else begin
              state <= SQ_IDLE;
            end
          end
          default: begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            else begin
              state    <= SQ_IDLE;
              slot_clk <= 1'b0;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/dac_frame_formatter.sv
module dac_frame_formatter
  import dacfmt_pkg::*;
#(
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned TAIL_CLKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i2s_bck,
  input  logic             i2s_ws,
  input  logic             i2s_sd,
  input  logic [1:0]       cfg_width,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_lead,
  input  logic             cfg_tail,
  input  logic             cfg_cont,
  input  logic             cfg_mono,
  output logic             dac_bck,
  output logic             dac_dl,
  output logic             dac_dr,
  output logic             dac_le,
  output logic             dac_le_aux
);
  logic              tick, pair_stb, ph, slot_clk, slot_start, le_int;
  logic [WORD_W-1:0] word_l, word_r;
  seq_e              seq_st;
  logic              seq_idle, seq_lead;

  assign seq_idle = (seq_st == SQ_IDLE);
  assign seq_lead = (seq_st == SQ_LEAD);

  i2s_pair_capture u_cap (
    .clk(clk), .rst_n(rst_n), .bck(i2s_bck), .ws(i2s_ws), .sd(i2s_sd),
    .pair_stb(pair_stb), .word_l(word_l), .word_r(word_r)
  );

  half_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .div(cfg_div), .tick(tick)
  );

  slot_sequencer #(.TAIL_CLKS(TAIL_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pair_stb(pair_stb),
    .word_l(word_l), .word_r(word_r), .cfg_width(cfg_width),
    .cfg_lead(cfg_lead), .cfg_tail(cfg_tail), .ph(ph), .slot_clk(slot_clk),
    .dl(dac_dl), .dr(dac_dr), .le(le_int), .slot_start(slot_start), .state(seq_st)
  );

  assign dac_bck    = ph & (cfg_cont | slot_clk);
  assign dac_le     = le_int;
  assign dac_le_aux = le_int & cfg_mono;
endmodule

// File: rtl/dacfmt_checker.sv
module dacfmt_checker (
  input logic clk,
  input logic rst_n,
  input logic cfg_cont,
  input logic cfg_mono,
  input logic bck,
  input logic dl,
  input logic dr,
  input logic le,
  input logic le_aux,
  input logic seq_idle,
  input logic seq_lead,
  input logic slot_start
);
  // R5
  latch_no_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (le && !cfg_cont) |-> !bck);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_idle && !cfg_cont) |-> !(bck || dl || dr || le));

  // R6
  latch_fall_on_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(le) |-> $past(slot_start));

  // R4
  rise_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bck) |-> ($stable(dl) && $stable(dr)));

  // R9
  lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_lead |-> (!dl && !dr));

  // R10
  aux_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le_aux == (le && cfg_mono));
endmodule

bind dac_frame_formatter dacfmt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_cont(cfg_cont), .cfg_mono(cfg_mono),
  .bck(dac_bck), .dl(dac_dl), .dr(dac_dr), .le(dac_le), .le_aux(dac_le_aux),
  .seq_idle(seq_idle), .seq_lead(seq_lead), .slot_start(slot_start)
);

// File: tb/test_dac_frame_formatter.sv
`timescale 1ns/1ps
module test_dac_frame_formatter;
  typedef struct packed {
    logic [1:0]  w;
    logic        lead, tail, mono, cont, s16;
    logic [1:0]  div;
    logic [31:0] l, r;
  } vec_t;

  localparam int NV = 8;
  localparam int TAIL_EXP = 2;
  localparam vec_t VEC [NV] = '{
    '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 32'hA5C3_0F12, 32'h5A3C_F0ED},
    '{2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 32'h8001_FFFF, 32'h7FFE_0001},
    '{2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 32'hC0DE_BEEF, 32'h1234_5678},
    '{2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 32'hF00D_CAFE, 32'h0BAD_F00D},
    '{2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 32'h8000_0000, 32'hFFFF_FFFF},
    '{2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 32'hDEAD_BEEF, 32'h0123_4567},
    '{2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd3, 32'hFFFF_FFFF, 32'h0000_0000},
    '{2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 32'h0000_ABCD, 32'h0000_8001}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic i2s_bck = 1'b0, i2s_ws = 1'b0, i2s_sd = 1'b0;
  logic [1:0] cfg_width;
  logic [7:0] cfg_div;
  logic cfg_lead, cfg_tail, cfg_cont, cfg_mono;
  logic dac_bck, dac_dl, dac_dr, dac_le, dac_le_aux;

  int checks = 0, fails = 0, cur_vi = 0, bursts = 0;
  bit done = 0, pend_bit = 0;

  always #10 clk = ~clk;

  dac_frame_formatter i_dac_frame_formatter (
    .clk(clk), .rst_n(rst_n), .i2s_bck(i2s_bck), .i2s_ws(i2s_ws), .i2s_sd(i2s_sd),
    .cfg_width(cfg_width), .cfg_div(cfg_div), .cfg_lead(cfg_lead), .cfg_tail(cfg_tail),
    .cfg_cont(cfg_cont), .cfg_mono(cfg_mono), .dac_bck(dac_bck), .dac_dl(dac_dl),
    .dac_dr(dac_dr), .dac_le(dac_le), .dac_le_aux(dac_le_aux)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int nbits(input logic [1:0] code);
    int t [4] = '{16, 18, 20, 24};
    return t[code];
  endfunction

  // bits the DAC should receive for one channel
  function automatic logic [63:0] expect_word(input logic [31:0] w, input logic s16, input int n);
    logic [63:0] kept;
    kept = s16 ? {40'd0, w[15:0], 8'd0} : {40'd0, w[31:8]};
    return kept >> (24 - n);
  endfunction

  task automatic apply_cfg(input int vi);
    cfg_width = VEC[vi].w;  cfg_lead = VEC[vi].lead; cfg_tail = VEC[vi].tail;
    cfg_mono  = VEC[vi].mono; cfg_cont = VEC[vi].cont; cfg_div = {6'd0, VEC[vi].div};
    cur_vi = vi;
  endtask

  // mid-frame point: previous burst is over, next not yet started
  task automatic mid_point(input int vi);
    if (!cfg_cont) check("R6 idle low", {60'd0, dac_bck, dac_dl, dac_dr, dac_le}, 64'd0);
    else           check("R7 idle data low", {61'd0, dac_dl, dac_dr, dac_le}, 64'd0);
    check("R11 one burst per pair", 64'(bursts), 64'(vi));
    apply_cfg(vi);
  endtask

  task automatic send_frame(input logic [31:0] l, input logic [31:0] r, input logic s16,
                            input bit upd, input int vi);
    int s;
    s = s16 ? 16 : 32;
    for (int j = 0; j < 2 * s; j++) begin
      bit cur;
      cur = (j < s) ? l[s-1-j] : r[2*s-1-j];
      @(negedge clk);
      if (upd && j == s + 8) mid_point(vi);
      i2s_bck = 1'b0; i2s_ws = (j >= s); i2s_sd = pend_bit; pend_bit = cur;
      repeat (8) @(negedge clk);
      i2s_bck = 1'b1;
      repeat (7) @(negedge clk);
    end
  endtask

  // output monitor
  logic bck_d = 0, le_d = 0, dl_d = 0, dr_d = 0;
  logic [63:0] mon_l = 0, mon_r = 0;
  int cyc = 0, last_rise = 0, period = 0, rises = 0, latch_rises = 0, stab_err = 0;
  int last_tail = 0;
  bit last_cont = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      vec_t v;
      int n;
      logic [63:0] mask;
      v = VEC[cur_vi];
      n = nbits(v.w);
      mask = (64'd1 << n) - 1;
      cyc++;
      if (dac_bck && !bck_d) begin
        rises++;
        period = cyc - last_rise; last_rise = cyc;
        mon_l = {mon_l[62:0], dac_dl}; mon_r = {mon_r[62:0], dac_dr};
        if (dac_le) latch_rises++;
        if (dac_dl !== dl_d || dac_dr !== dr_d) stab_err++;
      end
      if (dac_le && !le_d) begin
        string tg;
        tg = v.s16 ? "R3 zero pad" : (v.w == 2'd3 ? "R1 width" : "R2 truncate");
        check({tg, " left"},  mon_l & mask, expect_word(v.l, v.s16, n));
        check({tg, " right"}, mon_r & mask, expect_word(v.r, v.s16, n));
        check("R12 bit clock period", 64'(period), 64'(2 * v.div));
        check("R4 data stable at rise", 64'(stab_err), 64'd0);
        check("R10 aux latch", {63'd0, dac_le_aux}, {63'd0, v.mono});
        if (v.lead) check("R9 lead data low", {62'd0, mon_l[n], mon_r[n]}, 64'd0);
        if (!last_cont && !v.cont)
          check("R5 pulse count", 64'(rises), 64'(last_tail + int'(v.lead) + n));
        stab_err = 0; latch_rises = 0;
      end
      if (!dac_le && le_d) begin
        if (v.cont) check("R7 clock runs in latch", 64'(latch_rises), 64'd1);
        else        check("R5 no clock in latch", 64'(latch_rises), 64'd0);
        check("R6 data low at latch", {62'd0, dac_dl, dac_dr}, 64'd0);
        last_tail = v.tail ? TAIL_EXP : 0;
        last_cont = v.cont;
        rises = 0;
        bursts++;
      end
      bck_d = dac_bck; le_d = dac_le; dl_d = dac_dl; dr_d = dac_dr;
    end
  end

  initial begin
    apply_cfg(0);
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R11 reset outputs", {59'd0, dac_bck, dac_dl, dac_dr, dac_le, dac_le_aux}, 64'd0);
    send_frame(32'h1357_9BDF, 32'h2468_ACE0, 1'b0, 1'b0, 0);   // warm-up, discarded
    for (int i = 0; i < NV; i++)
      send_frame(VEC[i].l, VEC[i].r, VEC[i].s16, 1'b1, i);
    send_frame(32'd0, 32'd0, 1'b0, 1'b0, 0);                   // completes the last pair
    repeat (300) @(negedge clk);
    check("R11 total bursts", 64'(bursts), 64'(NV));
    check("R8 tail pulses", 64'(rises), 64'(TAIL_EXP));
    check("R6 final idle", {60'd0, dac_bck, dac_dl, dac_dr, dac_le}, 64'd0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule